// File: doc/BRIEF.md
# Event Timer Global Configuration and Interrupt Routing

This block is the global control stage of a three-timer event timer. It owns a 64-bit configuration word with two live bits, an overall run enable and a legacy-route select. It also owns a small word of sticky per-timer interrupt status bits. A register port accepts 32-bit and 64-bit accesses and checks their alignment. The enable bit gates a free-running main counter that sits outside the block through `cnt_en`. Timer match pulses arrive from comparator logic outside the block. Each one sets its timer's status bit while the block is running. Software clears a status bit by writing a 1 to it.

Pending status bits are turned into interrupt lines by a routing stage. In routed mode, each timer drives the interrupt-controller input chosen by its own 5-bit route field. In legacy mode, timers 0 and 1 drive fixed lines on both the 16-line programmable-controller vector and the 32-input advanced-controller vector, and their route fields are ignored. All interrupt outputs are held low while the enable is clear.

The two configuration bits are held as a four-state mode machine:

| State | Meaning |
|---|---|
| `MODE_HALT` | stopped, routed |
| `MODE_RUN` | running, routed |
| `MODE_HALT_LEG` | stopped, legacy |
| `MODE_RUN_LEG` | running, legacy |

The state encoding is the value `{legacy, enable}`. A legal configuration write moves the machine to the state named by write-data bits [1:0]. The transitions are named as follows:

| Transition | Move |
|---|---|
| `start` | HALT to RUN |
| `stop` | RUN to HALT |
| `go_legacy` | RUN to RUN_LEG, or HALT to HALT_LEG |
| `go_routed` | RUN_LEG to RUN, or HALT_LEG to HALT |

A write whose data names two changes at once moves directly to the target state. Every other request leaves the state unchanged, which is the `hold` transition.

Top module: `evt_timer_cfg`

## Requirements
- R1: After reset the mode machine is in `MODE_HALT`. The configuration word and the status word both read 0, `cnt_en` is 0, and `apic_irq` and `pic_irq` are 0.
- R2: The legal accesses are a 32-bit access (`req_size64`=0) at offset 10h, 14h, 20h or 24h, and a 64-bit access (`req_size64`=1) at offset 10h or 20h. Read data appears on `rsp_rdata` on the cycle after the request. A read at 10h returns the enable in bit 0 and legacy in bit 1. A read at 20h returns status bit t in bit t. A read at 14h or 24h returns 0.
- R3: Any other request is illegal, for example a 32-bit access at 11h or 17h, or a 64-bit access at 14h. An illegal request writes nothing and returns 0, and `acc_err` is 1 for exactly the following cycle.
- R4: `cnt_en` equals configuration bit 0 from the cycle after the write that sets it.
- R5: A match pulse on `match_pulse[t]` while the enable is 1 sets status bit t at that clock edge. A pulse while the enable is 0 leaves the bit clear.
- R6: A legal write at offset 20h clears status bit t where `req_wdata[t]`=1 and leaves the other bits alone. If a set and a clear of the same bit occur in the same cycle, the bit ends set.
- R7: Status bits that are pending when the enable goes from 1 to 0 stay set. While the enable is 0, all interrupt outputs are 0. The pending bits drive the outputs again after the block is re-enabled.
- R8: With bit 1 clear and the enable set, a pending timer t drives `apic_irq[route_t]`, where `route_t` is `route_sel[5t+4:5t]`. In this mode `pic_irq` stays 0.
- R9: With bits 1 and 0 both set, a pending timer 0 drives `pic_irq[0]` and `apic_irq[2]`, and a pending timer 1 drives `pic_irq[8]` and `apic_irq[8]`. Their route fields are ignored. Timer 2 still drives `apic_irq[route_2]`.
- R10: Bits 63:2 of the configuration word are reserved. Writes to them, including any write at 14h, have no effect, and they always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 64 | Write data; 32-bit accesses use bits 31:0 |
| rsp_rdata | output | 64 | Read data, valid on the cycle after the request |
| acc_err | output | 1 | One-cycle pulse after an illegal request |
| route_sel | input | 15 | Per-timer 5-bit advanced-controller route fields |
| match_pulse | input | 3 | Per-timer comparator match pulses |
| cnt_en | output | 1 | Main counter increment enable |
| apic_irq | output | 32 | Advanced-controller interrupt lines |
| pic_irq | output | 16 | Legacy programmable-controller interrupt lines |

## Verification
The hardest case to reach from the ports is a status bit that was set while running and is still pending after the enable drops. The bench reaches it in four steps. First it raises match pulses on all three timers while the block is enabled. Next it writes the configuration back to 0 through a 32-bit access and reads the status word to show the bits survived. Last it re-enables the block and checks that the same lines reappear without any new pulse. The same-cycle set-and-clear race is reached by driving a match pulse in the very cycle a status clear write is presented.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int NUM_TMR  = 3;
    localparam int ROUTE_W  = 5;
    localparam int APIC_W   = 1 << ROUTE_W;
    localparam int PIC_W    = 16;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 64;

    localparam logic [ADDR_W-1:0] CFG_OFS = 8'h10;
    localparam logic [ADDR_W-1:0] STS_OFS = 8'h20;

    localparam int LEG_T0_PIC  = 0;
    localparam int LEG_T0_APIC = 2;
    localparam int LEG_T1_PIC  = 8;
    localparam int LEG_T1_APIC = 8;

    // encoding is {legacy, enable}
    typedef enum logic [1:0] {
        MODE_HALT     = 2'b00,
        MODE_RUN      = 2'b01,
        MODE_HALT_LEG = 2'b10,
        MODE_RUN_LEG  = 2'b11
    } mode_e;
endpackage

// File: rtl/evt_acc_decode.sv
module evt_acc_decode
    import evt_timer_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              size64,
    output logic              legal,
    output logic              sel_cfg,
    output logic              sel_sts,
    output logic              upper
);
    logic cfg_lo, cfg_hi, sts_lo, sts_hi;

    always_comb begin
        cfg_lo = (addr == CFG_OFS);
        cfg_hi = (addr == CFG_OFS + 8'd4);
        sts_lo = (addr == STS_OFS);
        sts_hi = (addr == STS_OFS + 8'd4);
        if (size64) legal = cfg_lo | sts_lo;
        else        legal = cfg_lo | cfg_hi | sts_lo | sts_hi;
        sel_cfg = legal & (cfg_lo | cfg_hi);
        sel_sts = legal & (sts_lo | sts_hi);
        upper   = legal & (cfg_hi | sts_hi);
    end
endmodule

// File: rtl/evt_sts_latch.sv
module evt_sts_latch
    import evt_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [NUM_TMR-1:0] match,
    input  logic [NUM_TMR-1:0] clr,
    output logic [NUM_TMR-1:0] sts
);
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                 sts[t] <= 1'b0;
            else if (match[t] && run)   sts[t] <= 1'b1;
            else if (clr[t])            sts[t] <= 1'b0;
        end

        assert_set_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (match[t] && run) |=> sts[t]);
        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[t] && !clr[t]) |=> sts[t]);
        assert_no_set_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!sts[t] && !run) |=> !sts[t]);
    end
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
    import evt_timer_pkg::*;
(
    input  logic                       run,
    input  logic                       legacy,
    input  logic [NUM_TMR-1:0]         sts,
    input  logic [NUM_TMR*ROUTE_W-1:0] route_sel,
    output logic [APIC_W-1:0]          apic_irq,
    output logic [PIC_W-1:0]           pic_irq
);
    always_comb begin
        apic_irq = '0;
        pic_irq  = '0;
        if (run) begin
            for (int t = 0; t < NUM_TMR; t++) begin
                if (sts[t]) begin
                    if (legacy && t == 0) begin
                        apic_irq[LEG_T0_APIC] = 1'b1;
                        pic_irq[LEG_T0_PIC]   = 1'b1;
                    end else if (legacy && t == 1) begin
                        apic_irq[LEG_T1_APIC] = 1'b1;
                        pic_irq[LEG_T1_PIC]   = 1'b1;
                    end else begin
                        apic_irq[route_sel[t*ROUTE_W +: ROUTE_W]] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/evt_timer_cfg.sv
module evt_timer_cfg
    import evt_timer_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic                       req_size64,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       acc_err,
    input  logic [NUM_TMR*ROUTE_W-1:0] route_sel,
    input  logic [NUM_TMR-1:0]         match_pulse,
    output logic                       cnt_en,
    output logic [APIC_W-1:0]          apic_irq,
    output logic [PIC_W-1:0]           pic_irq
);
    mode_e              state, state_nx;
    logic               legal, sel_cfg, sel_sts, upper;
    logic               run, legacy;
    logic               cfg_wr, sts_wr;
    logic [NUM_TMR-1:0] sts, sts_clr;
    logic [DATA_W-1:0]  rd_nx;

    evt_acc_decode u_dec (
        .addr    (req_addr),
        .size64  (req_size64),
        .legal   (legal),
        .sel_cfg (sel_cfg),
        .sel_sts (sel_sts),
        .upper   (upper)
    );

    assign cfg_wr  = req_valid & req_write & sel_cfg & ~upper;
    assign sts_wr  = req_valid & req_write & sel_sts & ~upper;
    assign sts_clr = sts_wr ? req_wdata[NUM_TMR-1:0] : '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_HALT;
        else        state <= state_nx;
    end

    // transitions: start, stop, go_legacy, go_routed, hold
    always_comb begin
        state_nx = state;
        if (cfg_wr) begin
            unique case (req_wdata[1:0])
                2'b00:   state_nx = MODE_HALT;
                2'b01:   state_nx = MODE_RUN;
                2'b10:   state_nx = MODE_HALT_LEG;
                default: state_nx = MODE_RUN_LEG;
            endcase
        end
    end

    // outputs of the mode machine
    always_comb begin
        unique case (state)
            MODE_HALT:     begin run = 1'b0; legacy = 1'b0; end
            MODE_RUN:      begin run = 1'b1; legacy = 1'b0; end
            MODE_HALT_LEG: begin run = 1'b0; legacy = 1'b1; end
            default:       begin run = 1'b1; legacy = 1'b1; end
        endcase
    end
    assign cnt_en = run;

    evt_sts_latch u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .match (match_pulse),
        .clr   (sts_clr),
        .sts   (sts)
    );

    evt_irq_router u_rt (
        .run       (run),
        .legacy    (legacy),
        .sts       (sts),
        .route_sel (route_sel),
        .apic_irq  (apic_irq),
        .pic_irq   (pic_irq)
    );

    // read path
    always_comb begin
        rd_nx = '0;
        if (req_valid && !req_write && !upper) begin
            if (sel_cfg)      rd_nx[1:0]         = {legacy, run};
            else if (sel_sts) rd_nx[NUM_TMR-1:0] = sts;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
            acc_err   <= 1'b0;
        end else begin
            rsp_rdata <= rd_nx;
            acc_err   <= req_valid & ~legal;
        end
    end

    assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !legal) |=> acc_err);
    assert_illegal_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !legal) |=> $stable(state));
    assert_illegal_zero_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !legal) |=> (rsp_rdata == '0));
    assert_halt_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |-> (apic_irq == '0 && pic_irq == '0));
    assert_routed_pic_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_RUN) |-> (pic_irq == '0));
    assert_legacy_t0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_RUN_LEG && sts[0]) |-> (pic_irq[LEG_T0_PIC] && apic_irq[LEG_T0_APIC]));
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata[DATA_W-1:NUM_TMR] == '0));
endmodule

// File: tb/evt_timer_cfg_tb.sv
module evt_timer_cfg_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_size64 = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rsp_rdata;
    logic        acc_err;
    logic [14:0] route_sel = '0;
    logic [2:0]  match_pulse = '0;
    logic        cnt_en;
    logic [31:0] apic_irq;
    logic [15:0] pic_irq;

    int n_run = 0, n_fail = 0;
    logic [63:0] rd;
    logic        er;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer_cfg u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size64(req_size64), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .acc_err(acc_err), .route_sel(route_sel),
        .match_pulse(match_pulse), .cnt_en(cnt_en), .apic_irq(apic_irq), .pic_irq(pic_irq)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge
    task automatic access(input bit wr, input bit s64, input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size64 = s64; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd = rsp_rdata; er = acc_err;
    endtask

    task automatic pulse(input logic [2:0] m);
        @(negedge clk);
        match_pulse = m;
        @(negedge clk);
        match_pulse = '0;
    endtask

    task automatic t_reset;
        check(cnt_en == 1'b0, "R1 cnt_en", {63'd0, cnt_en}, 0);
        check(apic_irq == '0 && pic_irq == '0, "R1 irq", {16'd0, pic_irq, apic_irq}, 0);
        access(0, 1, 8'h10, 0);
        check(rd == 0, "R1 cfg read", rd, 0);
        access(0, 0, 8'h20, 0);
        check(rd == 0, "R1 sts read", rd, 0);
    endtask

    task automatic t_enable_and_legal;
        access(1, 0, 8'h10, 64'h1);
        check(er == 1'b0, "R2 legal 32b write no err", {63'd0, er}, 0);
        check(cnt_en == 1'b1, "R4 cnt_en set", {63'd0, cnt_en}, 1);
        access(0, 1, 8'h10, 0);
        check(rd == 64'h1, "R2 64b read cfg", rd, 1);
        access(0, 0, 8'h14, 0);
        check(rd == 0 && er == 0, "R2 read 14h zero", rd, 0);
    endtask

    task automatic t_reserved;
        access(1, 1, 8'h10, 64'hFFFF_FFFF_FFFF_FFFD);
        access(0, 1, 8'h10, 0);
        check(rd == 64'h1, "R10 reserved ignored", rd, 1);
        access(1, 0, 8'h14, 64'hFFFF_FFFF);
        access(0, 0, 8'h10, 0);
        check(rd == 64'h1, "R10 write at 14h ignored", rd, 1);
    endtask

    task automatic t_illegal;
        access(1, 0, 8'h11, 64'h0);
        check(er == 1'b1, "R3 err 32b at 11h", {63'd0, er}, 1);
        @(negedge clk);
        check(acc_err == 1'b0, "R3 err one cycle", {63'd0, acc_err}, 0);
        check(cnt_en == 1'b1, "R3 no write at 11h", {63'd0, cnt_en}, 1);
        access(0, 0, 8'h17, 0);
        check(er == 1'b1 && rd == 0, "R3 read 17h", rd, 0);
        access(1, 1, 8'h14, 64'h0);
        check(er == 1'b1, "R3 err 64b at 14h", {63'd0, er}, 1);
        check(cnt_en == 1'b1, "R3 no write 64b at 14h", {63'd0, cnt_en}, 1);
        access(0, 1, 8'h10, 0);
        check(rd == 64'h1, "R3 cfg unchanged", rd, 1);
    endtask

    task automatic t_routed;
        route_sel = {5'd20, 5'd9, 5'd5};
        pulse(3'b001);
        check(apic_irq == 32'h20, "R8 t0 to line 5", apic_irq, 32'h20);
        check(pic_irq == 0, "R8 pic quiet", pic_irq, 0);
        pulse(3'b110);
        check(apic_irq == 32'h0010_0220, "R8 three timers", apic_irq, 32'h0010_0220);
        access(0, 0, 8'h20, 0);
        check(rd == 64'h7, "R5 status read", rd, 7);
    endtask

    task automatic t_clear;
        access(1, 0, 8'h20, 64'h2);
        access(0, 0, 8'h20, 0);
        check(rd == 64'h5, "R6 clear only t1", rd, 5);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_size64 = 0; req_addr = 8'h20; req_wdata = 64'h1;
        match_pulse = 3'b001;
        @(negedge clk);
        req_valid = 0; req_write = 0; match_pulse = 0;
        access(0, 0, 8'h20, 0);
        check(rd == 64'h5, "R6 set wins", rd, 5);
        access(1, 1, 8'h20, 64'h7);
        access(0, 1, 8'h20, 0);
        check(rd == 0, "R6 clear all", rd, 0);
    endtask

    task automatic t_halt_hold;
        pulse(3'b111);
        access(1, 0, 8'h10, 64'h0);
        check(cnt_en == 0, "R4 cnt_en clear", {63'd0, cnt_en}, 0);
        check(apic_irq == 0 && pic_irq == 0, "R7 outputs off", {16'd0, pic_irq, apic_irq}, 0);
        access(0, 0, 8'h20, 0);
        check(rd == 64'h7, "R7 status kept", rd, 7);
        access(1, 0, 8'h20, 64'h7);
        pulse(3'b010);
        access(0, 0, 8'h20, 0);
        check(rd == 0, "R5 no set while halted", rd, 0);
        pulse(3'b000);
        access(1, 0, 8'h10, 64'h1);
        pulse(3'b111);
        access(1, 0, 8'h10, 64'h0);
        access(1, 0, 8'h10, 64'h1);
        check(apic_irq == 32'h0010_0220, "R7 pending lines return", apic_irq, 32'h0010_0220);
    endtask

    task automatic t_legacy;
        access(1, 0, 8'h10, 64'h3);
        check(apic_irq == 32'h0010_0104, "R9 legacy apic", apic_irq, 32'h0010_0104);
        check(pic_irq == 16'h0101, "R9 legacy pic", pic_irq, 16'h0101);
        route_sel = {5'd20, 5'd30, 5'd31};
        #1;
        check(apic_irq == 32'h0010_0104, "R9 t0 t1 routes ignored", apic_irq, 32'h0010_0104);
        access(1, 0, 8'h10, 64'h2);
        check(apic_irq == 0 && pic_irq == 0, "R7 legacy halted silent", {16'd0, pic_irq, apic_irq}, 0);
        access(0, 0, 8'h10, 0);
        check(rd == 64'h2, "R2 cfg reads legacy only", rd, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enable_and_legal;
        t_reserved;
        t_illegal;
        t_routed;
        t_clear;
        t_halt_hold;
        t_legacy;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule